// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and a 32K x 8 asynchronous static RAM that shares one bidirectional byte bus for reads and writes. The host hands over a single request at a time with a valid/ready handshake: a 15-bit word address, a direction bit and, for writes, a data byte. The controller then runs the memory's active-low chip-select, write-strobe and output-gate pins through a fixed sequence, and for reads it returns the fetched byte with a one-clock valid pulse.

Every analog timing minimum of the memory is expressed as a count of system clocks, set by parameters. These are the write strobe low width, the data setup before the strobe rises, the address-to-data delay and the gate-to-data delay. The sequences also keep the ordering rules that protect the shared bus and the address decoder. The write strobe is always the edge that ends a write, and the chip select is released one clock later. The address moves only while a strobe is inactive. A read is followed by at least one clock with the output gate high before the controller drives the bus again. All outputs come from registers, so the pins change only at clock edges.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycles after it, chip select, write strobe and output gate are all high (inactive), the controller does not drive the data bus, `req_ready` is 1 and `rd_valid` is 0.
- R2: The full 15-bit address space is reachable. A byte written to any address, including 0x0000 and 0x7FFF, is returned unchanged by a later read of that address, and other addresses are not disturbed.
- R3: A write holds chip select and write strobe low and output gate high for max(T_WP, T_DS) clocks. The controller drives the byte on the bus for that whole window, so the strobe low width is at least T_WP clocks and the data is stable for at least T_DS clocks before the strobe rises. The write strobe is never low while chip select is high. An accepted write takes max(T_WP, T_DS) + 2 clocks until `req_ready` returns.
- R4: The write strobe rises while chip select is still low. The controller stops driving the bus on that same edge, and chip select rises one clock later.
- R5: The memory address never changes in a cycle where chip select and write strobe were both low in the previous cycle and are still both low.
- R6: A read holds chip select and output gate low with the write strobe high. The bus is captured at the end of the max(T_AA, T_OE)-th cycle of that window, never earlier. `rd_valid` is seen max(T_AA, T_OE) + 1 clocks after the accepting edge.
- R7: Between any cycle with the output gate low and the first cycle in which the controller drives the bus, there is at least one cycle with the output gate high. The controller and the memory never drive the bus at the same time.
- R8: A request is taken only on a clock where both `req_valid` and `req_ready` are 1. `req_ready` is 0 from the accepting edge until the access ends. A request presented and withdrawn while `req_ready` is 0 has no effect on the memory.
- R9: `rd_valid` is high for exactly one clock per read, with `rd_data` holding the captured byte in that clock.
- R10: Back-to-back requests work. A read straight after a write to the same address returns the new byte, and a write straight after a read is carried out correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address of the request |
| req_wdata | input | 8 | Byte to write |
| rd_valid | output | 1 | One-clock pulse when read data is returned |
| rd_data | output | 8 | Byte returned by the read |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output gate, active low |
| mem_addr | output | 15 | Memory address bus |
| mem_dq | inout | 8 | Shared memory data bus |

## Verification
The assertions assume that the host keeps to the handshake and that the memory drives the bus only when chip select and output gate are low with the write strobe high. Under these assumptions, any overlap on the bus can only come from the controller's own drive timing. The bench meets the assumption with a behavioural memory that drives the bus only from that strobe combination. Until the programmed access time has passed, this memory returns the inverted byte, so an early capture shows up as wrong data. The host side of the bench changes its inputs only on falling edges. It holds `req_valid` through the accepting edge, and it withdraws a request it raised while busy before ready returns.

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int T_WP   = 3,
  parameter int T_DS   = 2,
  parameter int T_AA   = 3,
  parameter int T_OE   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq
);
  localparam int T_WL  = (T_WP > T_DS) ? T_WP : T_DS;
  localparam int T_RD  = (T_AA > T_OE) ? T_AA : T_OE;
  localparam int T_MAX = (T_WL > T_RD) ? T_WL : T_RD;
  localparam int CW    = $clog2(T_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_WR, S_WEND, S_RD} state_t;

  state_t            state;
  logic [CW-1:0]     cnt;
  logic              bus_drv;
  logic [DATA_W-1:0] wdata_q;

  assign req_ready = (state == S_IDLE);
  assign mem_dq    = bus_drv ? wdata_q : {DATA_W{1'bz}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      mem_ce_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_oe_n <= 1'b1;
      bus_drv  <= 1'b0;
      mem_addr <= '0;
      wdata_q  <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          mem_addr <= req_addr;
          mem_ce_n <= 1'b0;
          cnt      <= '0;
          if (req_write) begin
            wdata_q  <= req_wdata;
            mem_we_n <= 1'b0;
            bus_drv  <= 1'b1;
            state    <= S_WR;
          end else begin
            mem_oe_n <= 1'b0;
            state    <= S_RD;
          end
        end
        S_WR: begin
          cnt <= cnt + CW'(1);
          if (cnt == CW'(T_WL - 1)) begin
            mem_we_n <= 1'b1;
            bus_drv  <= 1'b0;
            state    <= S_WEND;
          end
        end
        S_WEND: begin
          mem_ce_n <= 1'b1;
          state    <= S_IDLE;
        end
        S_RD: begin
          cnt <= cnt + CW'(1);
          if (cnt == CW'(T_RD - 1)) begin
            rd_data  <= mem_dq;
            rd_valid <= 1'b1;
            mem_ce_n <= 1'b1;
            mem_oe_n <= 1'b1;
            state    <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3
  we_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);

  // R4
  we_ends_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce_n && !bus_drv));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !mem_we_n && $past(!mem_ce_n && !mem_we_n)) |-> $stable(mem_addr));

  // R7
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_drv) |-> $past(mem_oe_n));

  // R6
  read_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!mem_ce_n && !mem_oe_n && mem_we_n));

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R9
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
endmodule

// File: tb/test_sram_ctrl.sv
`timescale 1ns/1ps
module test_sram_ctrl;
  localparam int AW = 15;
  localparam int DW = 8;
  localparam int P_WP = 3;
  localparam int P_DS = 2;
  localparam int P_AA = 3;
  localparam int P_OE = 1;
  localparam int WL = (P_WP > P_DS) ? P_WP : P_DS;
  localparam int RL = (P_AA > P_OE) ? P_AA : P_OE;
  localparam int NV = 13;
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 15'h0000, 8'h3C}, {1'b1, 15'h7FFF, 8'hC3}, {1'b0, 15'h0000, 8'h00},
    {1'b0, 15'h7FFF, 8'h00}, {1'b1, 15'h1234, 8'h5A}, {1'b0, 15'h1234, 8'h00},
    {1'b1, 15'h1234, 8'hA5}, {1'b0, 15'h1234, 8'h00}, {1'b1, 15'h0001, 8'hFF},
    {1'b0, 15'h0001, 8'h00}, {1'b0, 15'h0000, 8'h00}, {1'b1, 15'h4000, 8'h00},
    {1'b0, 15'h4000, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid, mem_ce_n, mem_we_n, mem_oe_n;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] mem_addr;
  wire  [DW-1:0] mem_dq;

  always #2 clk = ~clk;

  sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .T_WP(P_WP), .T_DS(P_DS), .T_AA(P_AA), .T_OE(P_OE)) i_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq(mem_dq));

  // behavioural memory
  logic [DW-1:0] marr [int];
  logic [DW-1:0] mdl_val = '0;
  logic mdl_drv;
  assign mdl_drv = !mem_ce_n && mem_we_n && !mem_oe_n;
  assign mem_dq = mdl_drv ? mdl_val : {DW{1'bz}};

  function automatic logic [DW-1:0] mrd(input logic [AW-1:0] a);
    return marr.exists(int'(a)) ? marr[int'(a)] : (8'h96 ^ a[7:0]);
  endfunction

  int v_addr = 0, v_wr = 0, v_ce = 0, v_turn = 0;
  int wp = 0, ds = 0, acc = 0;
  bit p_wr = 0, p_rd = 0, p_oe = 0;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_dq = '0;

  always @(negedge clk) begin
    bit c_wr, c_rd;
    c_wr = !mem_ce_n && !mem_we_n;
    c_rd = mdl_drv;
    if (rst_n) begin
      if (c_wr && p_wr && mem_addr != p_addr) v_addr++;
      if (c_wr && !mem_oe_n) v_wr++;
      if (c_wr && p_oe) v_turn++;
      if (c_wr) begin
        wp = p_wr ? wp + 1 : 1;
        ds = (p_wr && mem_dq == p_dq) ? ds + 1 : 1;
      end
      if (p_wr && !c_wr) begin
        marr[int'(p_addr)] = p_dq;
        if (wp < P_WP || ds < P_DS) v_wr++;
        if (mem_ce_n) v_ce++;
      end
      if (c_rd) begin
        if (p_rd && mem_addr == p_addr && mem_dq !== mdl_val) v_turn++;
        acc = (p_rd && mem_addr == p_addr) ? acc + 1 : 1;
        mdl_val = (acc >= RL) ? mrd(mem_addr) : ~mrd(mem_addr);
      end
    end
    p_wr = c_wr;
    p_rd = c_rd;
    p_oe = !mem_ce_n && !mem_oe_n;
    p_addr = mem_addr;
    p_dq = mem_dq;
  end

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] shadow [int];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       output logic [DW-1:0] got, output int lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    chk(!req_ready, "R8 ready low after accept", int'(req_ready), 0);
    while (!(w ? req_ready : rd_valid) && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    got = rd_data;
    if (!w) begin
      @(negedge clk);
      chk(!rd_valid, "R9 rd_valid one clock", int'(rd_valid), 0);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] got;
    int lat;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes high in reset",
        int'({mem_ce_n, mem_we_n, mem_oe_n}), 7);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes high after reset",
        int'({mem_ce_n, mem_we_n, mem_oe_n}), 7);
    chk(req_ready && !rd_valid, "R1 ready high, no rd_valid", int'({req_ready, rd_valid}), 2);

    for (int i = 0; i < NV; i++) begin
      logic w;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      w = VEC[i][23]; a = VEC[i][22:8]; d = VEC[i][7:0];
      do_op(w, a, d, got, lat);
      if (w) begin
        shadow[int'(a)] = d;
        chk(lat == WL + 2, "R3 write latency", lat, WL + 2);
      end else begin
        chk(lat == RL + 1, "R6 read latency", lat, RL + 1);
        chk(got == shadow[int'(a)], "R2 R10 read data", int'(got), int'(shadow[int'(a)]));
      end
    end

    // R8: request raised and withdrawn while busy is ignored
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 15'h1234;
    @(negedge clk);
    req_write = 1'b1; req_wdata = 8'h00;
    chk(!req_ready, "R8 busy during read", int'(req_ready), 0);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rd_valid) @(negedge clk);
    chk(rd_data == 8'hA5, "R9 rd_data with pulse", int'(rd_data), 8'hA5);
    do_op(1'b0, 15'h1234, 8'h00, got, lat);
    chk(got == 8'hA5, "R8 withdrawn request had no effect", int'(got), 8'hA5);

    // R10: write straight after read, then read back
    do_op(1'b1, 15'h1234, 8'h77, got, lat);
    do_op(1'b0, 15'h1234, 8'h00, got, lat);
    chk(got == 8'h77, "R10 write after read", int'(got), 8'h77);
    do_op(1'b0, 15'h7FFF, 8'h00, got, lat);
    chk(got == 8'hC3, "R2 top address undisturbed", int'(got), 8'hC3);

    repeat (3) @(negedge clk);
    chk(v_wr == 0, "R3 write strobe width/setup", v_wr, 0);
    chk(v_ce == 0, "R4 chip select held past write end", v_ce, 0);
    chk(v_addr == 0, "R5 address stable under strobes", v_addr, 0);
    chk(v_turn == 0, "R7 bus turnaround", v_turn, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule